// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block performs the privileged-state update that happens when a processor core accepts a synchronous exception or an interrupt. On a one-cycle take strobe it decides whether the supervisor or the machine level handles the trap. It then rewrites the status word, loads the cause, exception-PC and trap-value registers of the chosen level, and produces the handler address and the new privilege. All of this happens in a single clock.

The level is chosen with two per-cause delegation masks, one for interrupts and one for exceptions, indexed by the cause code. An environment call arrives with one generic cause code and is renumbered according to the privilege it was issued from before the mask is consulted. Handler addresses come from a per-level vector base, and interrupts may use a vectored table. A one-cycle pulse tells the memory system to drop any load reservation whenever the trap changes the privilege.

Top module: `trap_entry_unit`

## Requirements
- R1: After synchronous reset, every CSR output, `status_o` and `next_pc_o` are zero, `next_priv_o` is machine (3), and `done_o` and `resv_clr_o` are low.
- R2: Privilege encoding is user=0, supervisor=1, machine=3. A trap goes to supervisor when `priv_i` is 0 or 1 and the bit of the delegation mask at the index of the (remapped) cause is set. The mask is `irq_deleg_i` for interrupts and `exc_deleg_i` for exceptions.
- R3: In every other case the trap goes to machine, including every trap taken from machine whatever the masks hold.
- R4: On supervisor entry, status bit 5 takes the old bit 1, bit 8 takes `priv_i[0]`, and bit 1 is cleared. All other status bits pass through from `status_i`.
- R5: On machine entry, status bit 7 takes the old bit 3, bits 12:11 take `priv_i`, and bit 3 is cleared. All other status bits pass through.
- R6: The cause register of the target level becomes the 5-bit cause in bits 4:0, with the top bit set for an interrupt and all other bits zero. The other level's cause, exception-PC and trap-value registers keep their values.
- R7: The exception-PC register of the target level takes `pc_i`.
- R8: `next_pc_o` is the target level's vector base with bits 1:0 cleared. When the trap is an interrupt and the base's bits 1:0 equal 1, four times the cause is added. Exceptions and base modes 0, 2 and 3 use no offset.
- R9: For an exception with cause 0, 1, 4, 5, 6, 7, 12, 13 or 15, the trap-value register takes `fault_addr_i`. For every other exception and for every interrupt it takes zero.
- R10: An exception with cause 8 is renumbered by `priv_i`: user gives 8, supervisor gives 9, machine gives 11. The renumbered code is both the code used for delegation and the code recorded.
- R11: `done_o` pulses for exactly the cycle after each take strobe. Without a strobe, all outputs hold.
- R12: `resv_clr_o` pulses together with `done_o` when the new privilege differs from `priv_i`, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_i | input | 1 | Take-trap strobe, one cycle per trap |
| is_irq_i | input | 1 | 1 = interrupt, 0 = synchronous exception |
| cause_i | input | 5 | Raw cause code |
| fault_addr_i | input | 32 | Faulting address |
| pc_i | input | 32 | PC of the trapping instruction |
| priv_i | input | 2 | Current privilege |
| irq_deleg_i | input | 32 | Interrupt delegation mask |
| exc_deleg_i | input | 32 | Exception delegation mask |
| m_vec_i | input | 32 | Machine vector base and mode |
| s_vec_i | input | 32 | Supervisor vector base and mode |
| status_i | input | 32 | Current status word |
| done_o | output | 1 | Entry completed pulse |
| next_pc_o | output | 32 | Handler address |
| next_priv_o | output | 2 | Privilege after entry |
| status_o | output | 32 | Updated status word |
| s_cause_o | output | 32 | Supervisor cause register |
| s_epc_o | output | 32 | Supervisor exception PC |
| s_tval_o | output | 32 | Supervisor trap value |
| m_cause_o | output | 32 | Machine cause register |
| m_epc_o | output | 32 | Machine exception PC |
| m_tval_o | output | 32 | Machine trap value |
| resv_clr_o | output | 1 | Load-reservation clear pulse |

## Verification
The hardest case to reach is an environment call whose delegation depends on the renumbered code and not on the raw one. The stimulus sets the mask bit for code 8 and clears the bit for code 9, then raises a call from supervisor. It must land in machine with cause 9. Vectored offsets are reached by pairing interrupts and exceptions with a mode-1 base, and the hold behaviour is observed in the idle cycles between entries. Randomised traps mix privileges, masks and vector modes, and a model in the bench tracks both levels' registers.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  // status word bit positions decoded by neighbouring logic
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;

  // environment call codes per issuing privilege
  localparam int ECALL_FROM_U = 8;
  localparam int ECALL_FROM_S = 9;
  localparam int ECALL_FROM_M = 11;

  // per-level register bank index
  localparam int LVL_S = 0;
  localparam int LVL_M = 1;
  localparam int NUM_LVL = 2;

endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CW   = 5
) (
  input  logic            is_irq,
  input  logic [CW-1:0]   cause_raw,
  input  logic [1:0]      priv,
  input  logic [XLEN-1:0] irq_deleg,
  input  logic [XLEN-1:0] exc_deleg,
  output logic [CW-1:0]   cause_eff,
  output logic            to_super,
  output logic            keep_addr
);

  logic [XLEN-1:0] mask;
  logic            mask_bit;

  // renumber the generic environment call by issuing privilege
  always_comb begin
    cause_eff = cause_raw;
    if (!is_irq && (cause_raw == CW'(ECALL_FROM_U))) begin
      unique case (priv)
        PRIV_S:  cause_eff = CW'(ECALL_FROM_S);
        PRIV_M:  cause_eff = CW'(ECALL_FROM_M);
        default: cause_eff = CW'(ECALL_FROM_U);
      endcase
    end
  end

  assign mask = is_irq ? irq_deleg : exc_deleg;

  always_comb begin
    mask_bit = 1'b0;
    for (int i = 0; i < XLEN; i++) begin
      if (32'(cause_eff) == i) mask_bit = mask[i];
    end
  end

  assign to_super = ((priv == PRIV_U) || (priv == PRIV_S)) && mask_bit;

  // causes that carry an address into the trap-value register
  always_comb begin
    keep_addr = 1'b0;
    if (!is_irq) begin
      unique case (32'(cause_eff))
        0, 1, 4, 5, 6, 7, 12, 13, 15: keep_addr = 1'b1;
        default:                      keep_addr = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
  parameter int XLEN = 32,
  parameter int CW   = 5
) (
  input  logic [XLEN-1:0] vec_base,
  input  logic            is_irq,
  input  logic [CW-1:0]   cause,
  output logic [XLEN-1:0] target_pc
);

  localparam logic [1:0] MODE_TABLE = 2'd1;

  logic [XLEN-1:0] aligned;
  logic [XLEN-1:0] offset;

  assign aligned = {vec_base[XLEN-1:2], 2'b00};
  assign offset  = (is_irq && (vec_base[1:0] == MODE_TABLE))
                   ? (XLEN'(cause) << 2) : '0;
  assign target_pc = aligned + offset;

endmodule

// File: rtl/trap_status_stack.sv
module trap_status_stack
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] status_in,
  input  logic [1:0]      priv,
  input  logic            to_super,
  output logic [XLEN-1:0] status_out
);

  always_comb begin
    status_out = status_in;
    if (to_super) begin
      status_out[ST_SPIE] = status_in[ST_SIE];
      status_out[ST_SPP]  = priv[0];
      status_out[ST_SIE]  = 1'b0;
    end else begin
      status_out[ST_MPIE]          = status_in[ST_MIE];
      status_out[ST_MPP +: 2]      = priv;
      status_out[ST_MIE]           = 1'b0;
    end
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_i,
  input  logic            is_irq_i,
  input  logic [CW-1:0]   cause_i,
  input  logic [XLEN-1:0] fault_addr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [1:0]      priv_i,
  input  logic [XLEN-1:0] irq_deleg_i,
  input  logic [XLEN-1:0] exc_deleg_i,
  input  logic [XLEN-1:0] m_vec_i,
  input  logic [XLEN-1:0] s_vec_i,
  input  logic [XLEN-1:0] status_i,
  output logic            done_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [1:0]      next_priv_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] s_cause_o,
  output logic [XLEN-1:0] s_epc_o,
  output logic [XLEN-1:0] s_tval_o,
  output logic [XLEN-1:0] m_cause_o,
  output logic [XLEN-1:0] m_epc_o,
  output logic [XLEN-1:0] m_tval_o,
  output logic            resv_clr_o
);

  localparam int PAD_W = XLEN - 1 - CW;

  logic [CW-1:0]   cause_eff;
  logic            to_super;
  logic            keep_addr;
  logic [XLEN-1:0] vec_sel;
  logic [XLEN-1:0] tgt_pc;
  logic [XLEN-1:0] status_nxt;
  logic [1:0]      priv_nxt;
  logic [XLEN-1:0] cause_word;
  logic [XLEN-1:0] tval_word;

  trap_route #(.XLEN(XLEN), .CW(CW)) u_route (
    .is_irq    (is_irq_i),
    .cause_raw (cause_i),
    .priv      (priv_i),
    .irq_deleg (irq_deleg_i),
    .exc_deleg (exc_deleg_i),
    .cause_eff (cause_eff),
    .to_super  (to_super),
    .keep_addr (keep_addr)
  );

  assign vec_sel = to_super ? s_vec_i : m_vec_i;

  trap_vector #(.XLEN(XLEN), .CW(CW)) u_vector (
    .vec_base  (vec_sel),
    .is_irq    (is_irq_i),
    .cause     (cause_eff),
    .target_pc (tgt_pc)
  );

  trap_status_stack #(.XLEN(XLEN)) u_stack (
    .status_in  (status_i),
    .priv       (priv_i),
    .to_super   (to_super),
    .status_out (status_nxt)
  );

  assign priv_nxt   = to_super ? PRIV_S : PRIV_M;
  assign cause_word = {is_irq_i, {PAD_W{1'b0}}, cause_eff};
  assign tval_word  = keep_addr ? fault_addr_i : '0;

  // shared outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o      <= 1'b0;
      resv_clr_o  <= 1'b0;
      next_pc_o   <= '0;
      next_priv_o <= PRIV_M;
      status_o    <= '0;
    end else begin
      done_o     <= take_i;
      resv_clr_o <= take_i && (priv_nxt != priv_i);
      if (take_i) begin
        next_pc_o   <= tgt_pc;
        next_priv_o <= priv_nxt;
        status_o    <= status_nxt;
      end
    end
  end

  // per-level trap registers
  logic [XLEN-1:0] cause_q [NUM_LVL];
  logic [XLEN-1:0] epc_q   [NUM_LVL];
  logic [XLEN-1:0] tval_q  [NUM_LVL];

  for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
    logic hit;
    assign hit = take_i && ((lv == LVL_S) ? to_super : !to_super);
    always_ff @(posedge clk) begin
      if (rst) begin
        cause_q[lv] <= '0;
        epc_q[lv]   <= '0;
        tval_q[lv]  <= '0;
      end else if (hit) begin
        cause_q[lv] <= cause_word;
        epc_q[lv]   <= pc_i;
        tval_q[lv]  <= tval_word;
      end
    end
  end

  assign s_cause_o = cause_q[LVL_S];
  assign s_epc_o   = epc_q[LVL_S];
  assign s_tval_o  = tval_q[LVL_S];
  assign m_cause_o = cause_q[LVL_M];
  assign m_epc_o   = epc_q[LVL_M];
  assign m_tval_o  = tval_q[LVL_M];

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN = 32,
  parameter int CW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            take_i,
  input logic            is_irq_i,
  input logic [XLEN-1:0] pc_i,
  input logic [1:0]      priv_i,
  input logic [XLEN-1:0] status_i,
  input logic            done_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic [1:0]      next_priv_o,
  input logic [XLEN-1:0] status_o,
  input logic [XLEN-1:0] m_cause_o,
  input logic [XLEN-1:0] m_epc_o,
  input logic            resv_clr_o
);

  a_r11_done_follows_take: assert property (@(posedge clk) disable iff (rst)
    take_i |=> done_o);

  a_r11_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> !done_o);

  a_r11_outputs_hold: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> ($stable(next_pc_o) && $stable(status_o) && $stable(next_priv_o)));

  a_r3_machine_stays: assert property (@(posedge clk) disable iff (rst)
    (take_i && priv_i == 2'd3) |=> (next_priv_o == 2'd3));

  a_r4_super_stack: assert property (@(posedge clk) disable iff (rst)
    (take_i && priv_i != 2'd3) |=> ((next_priv_o != 2'd1) ||
      (!status_o[1] && status_o[5] == $past(status_i[1]))));

  a_r5_machine_stack: assert property (@(posedge clk) disable iff (rst)
    take_i |=> ((next_priv_o != 2'd3) ||
      (!status_o[3] && status_o[7] == $past(status_i[3]) &&
       status_o[12:11] == $past(priv_i))));

  a_r6_irq_flag: assert property (@(posedge clk) disable iff (rst)
    take_i |=> ((next_priv_o != 2'd3) || (m_cause_o[XLEN-1] == $past(is_irq_i))));

  a_r7_machine_epc: assert property (@(posedge clk) disable iff (rst)
    take_i |=> ((next_priv_o != 2'd3) || (m_epc_o == $past(pc_i))));

  a_r8_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (next_pc_o[1:0] == 2'b00));

  a_r12_resv_with_done: assert property (@(posedge clk) disable iff (rst)
    resv_clr_o |-> done_o);

  a_r12_resv_on_change: assert property (@(posedge clk) disable iff (rst)
    take_i |=> (resv_clr_o == (next_priv_o != $past(priv_i))));

endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .CW(CW)) u_trap_entry_chk (
  .clk         (clk),
  .rst         (rst),
  .take_i      (take_i),
  .is_irq_i    (is_irq_i),
  .pc_i        (pc_i),
  .priv_i      (priv_i),
  .status_i    (status_i),
  .done_o      (done_o),
  .next_pc_o   (next_pc_o),
  .next_priv_o (next_priv_o),
  .status_o    (status_o),
  .m_cause_o   (m_cause_o),
  .m_epc_o     (m_epc_o),
  .resv_clr_o  (resv_clr_o)
);

// File: tb/test_trap_entry_unit.sv
`timescale 1ns/1ps
module test_trap_entry_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        take_i = 1'b0;
  logic        is_irq_i = 1'b0;
  logic [4:0]  cause_i = '0;
  logic [31:0] fault_addr_i = '0, pc_i = '0;
  logic [1:0]  priv_i = 2'd3;
  logic [31:0] irq_deleg_i = '0, exc_deleg_i = '0;
  logic [31:0] m_vec_i = '0, s_vec_i = '0, status_i = '0;
  logic        done_o, resv_clr_o;
  logic [31:0] next_pc_o, status_o;
  logic [1:0]  next_priv_o;
  logic [31:0] s_cause_o, s_epc_o, s_tval_o, m_cause_o, m_epc_o, m_tval_o;

  always #4 clk = ~clk;

  trap_entry_unit i_trap_entry_unit (
    .clk(clk), .rst(rst), .take_i(take_i), .is_irq_i(is_irq_i),
    .cause_i(cause_i), .fault_addr_i(fault_addr_i), .pc_i(pc_i),
    .priv_i(priv_i), .irq_deleg_i(irq_deleg_i), .exc_deleg_i(exc_deleg_i),
    .m_vec_i(m_vec_i), .s_vec_i(s_vec_i), .status_i(status_i),
    .done_o(done_o), .next_pc_o(next_pc_o), .next_priv_o(next_priv_o),
    .status_o(status_o), .s_cause_o(s_cause_o), .s_epc_o(s_epc_o),
    .s_tval_o(s_tval_o), .m_cause_o(m_cause_o), .m_epc_o(m_epc_o),
    .m_tval_o(m_tval_o), .resv_clr_o(resv_clr_o)
  );

  typedef struct {
    logic [31:0] pc, st, sc, se, stv, mc, me, mtv;
    logic [1:0]  pr;
    logic        resv;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t last_e;
  int   n_chk = 0;
  int   n_err = 0;
  logic [31:0] sh_sc = '0, sh_se = '0, sh_stv = '0, sh_mc = '0, sh_me = '0, sh_mtv = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // driver: build expected item from the requirements, then strobe
  task automatic do_trap(input bit irq, input logic [4:0] c, input logic [31:0] addr,
                         input logic [31:0] pc, input logic [1:0] pr,
                         input logic [31:0] idl, input logic [31:0] edl,
                         input logic [31:0] mv, input logic [31:0] sv,
                         input logic [31:0] st, input string tag);
    exp_t e;
    logic [4:0]  ce;
    logic [31:0] dl, vec, tv, cr, ns;
    bit sup;
    ce = c;
    if (!irq && c == 5'd8) ce = (pr == 2'd1) ? 5'd9 : (pr == 2'd3) ? 5'd11 : 5'd8; // R10
    dl  = irq ? idl : edl;
    sup = (pr <= 2'd1) && dl[ce];                                                  // R2 R3
    tv  = (!irq && (ce inside {0, 1, 4, 5, 6, 7, 12, 13, 15})) ? addr : 32'd0;    // R9
    cr  = {irq, 26'd0, ce};                                                        // R6
    vec = sup ? sv : mv;
    e.pc = {vec[31:2], 2'b00} + ((irq && vec[1:0] == 2'd1) ? {25'd0, ce, 2'b00} : 32'd0); // R8
    ns = st;
    if (sup) begin ns[5] = st[1]; ns[8] = pr[0]; ns[1] = 1'b0; end                 // R4
    else begin ns[7] = st[3]; ns[12:11] = pr; ns[3] = 1'b0; end                    // R5
    e.st = ns;
    e.pr = sup ? 2'd1 : 2'd3;
    e.resv = (e.pr != pr);                                                         // R12
    if (sup) begin sh_sc = cr; sh_se = pc; sh_stv = tv; end                        // R7
    else begin sh_mc = cr; sh_me = pc; sh_mtv = tv; end
    e.sc = sh_sc; e.se = sh_se; e.stv = sh_stv;
    e.mc = sh_mc; e.me = sh_me; e.mtv = sh_mtv;
    e.tag = tag;
    @(negedge clk);
    is_irq_i = irq; cause_i = c; fault_addr_i = addr; pc_i = pc; priv_i = pr;
    irq_deleg_i = idl; exc_deleg_i = edl; m_vec_i = mv; s_vec_i = sv; status_i = st;
    take_i = 1'b1;
    q.push_back(e);
    @(negedge clk);
    take_i = 1'b0;
  endtask

  task automatic cmp_all(input exp_t e, input bit pulse_exp, input string req_pulse);
    chk(done_o == pulse_exp, "R11", {e.tag, " done"}, 32'(done_o), 32'(pulse_exp));
    chk(next_pc_o == e.pc, "R8", {e.tag, " next_pc"}, next_pc_o, e.pc);
    chk(next_priv_o == e.pr, "R2", {e.tag, " next_priv"}, 32'(next_priv_o), 32'(e.pr));
    chk(status_o == e.st, "R4", {e.tag, " status"}, status_o, e.st);
    chk(s_cause_o == e.sc, "R6", {e.tag, " s_cause"}, s_cause_o, e.sc);
    chk(s_epc_o == e.se, "R7", {e.tag, " s_epc"}, s_epc_o, e.se);
    chk(s_tval_o == e.stv, "R9", {e.tag, " s_tval"}, s_tval_o, e.stv);
    chk(m_cause_o == e.mc, "R10", {e.tag, " m_cause"}, m_cause_o, e.mc);
    chk(m_epc_o == e.me, "R7", {e.tag, " m_epc"}, m_epc_o, e.me);
    chk(m_tval_o == e.mtv, "R9", {e.tag, " m_tval"}, m_tval_o, e.mtv);
    chk(resv_clr_o == (pulse_exp && e.resv), req_pulse, {e.tag, " resv_clr"},
        32'(resv_clr_o), 32'(pulse_exp && e.resv));
  endtask

  // monitor: pop on completion, check hold in idle cycles
  bit started = 0;
  always @(negedge clk) begin
    if (!rst && started) begin
      if (done_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R11", "unexpected done", 32'd1, 32'd0);
        end else begin
          last_e = q.pop_front();
          cmp_all(last_e, 1'b1, "R12");
        end
      end else begin
        cmp_all(last_e, 1'b0, "R12");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R11 watchdog expired: actual=0 expected=1");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(done_o == 1'b0, "R1", "done", 32'(done_o), 0);
    chk(resv_clr_o == 1'b0, "R1", "resv", 32'(resv_clr_o), 0);
    chk(next_priv_o == 2'd3, "R1", "priv", 32'(next_priv_o), 3);
    chk(next_pc_o == 0 && status_o == 0, "R1", "pc|status", next_pc_o | status_o, 0);
    chk((s_cause_o | s_epc_o | s_tval_o | m_cause_o | m_epc_o | m_tval_o) == 0, "R1",
        "csrs", s_cause_o | s_epc_o | s_tval_o | m_cause_o | m_epc_o | m_tval_o, 0);
    last_e = '{pc: 0, st: 0, sc: 0, se: 0, stv: 0, mc: 0, me: 0, mtv: 0,
               pr: 2'd3, resv: 1'b0, tag: "reset"};
    started = 1;

    // R2: delegated illegal-instruction from user, tval zero (R9)
    do_trap(0, 5'd2, 32'hDEAD_0000, 32'h0000_1000, 2'd0, 0, 32'h4, 32'h8000_0000,
            32'h4000_0100, 32'h0000_0002, "R2 deleg exc");
    // R3: load page fault not delegated, tval = addr
    do_trap(0, 5'd13, 32'hCAFE_1234, 32'h0000_2000, 2'd0, 0, 32'h4, 32'h8000_0001,
            32'h4000_0100, 32'h0000_0008, "R3 undeleg");
    // R3 R12: from machine with all masks set, no privilege change
    do_trap(0, 5'd5, 32'h1111_2222, 32'h0000_3000, 2'd3, '1, '1, 32'h8000_0200,
            32'h4000_0000, 32'h0000_1888, "R3 from M");
    // R8: delegated interrupt, vectored supervisor base
    do_trap(1, 5'd5, 32'hFFFF_FFFF, 32'h0000_4000, 2'd1, 32'h20, 0, 32'h8000_0000,
            32'h4000_0101, 32'h0000_0022, "R8 s vectored");
    // R8: machine vectored interrupt from user
    do_trap(1, 5'd7, 32'h0, 32'h0000_5000, 2'd0, 0, 0, 32'h8000_0301,
            32'h4000_0000, 32'h0000_00AA, "R8 m vectored");
    // R8: exception with vectored base gets no offset
    do_trap(0, 5'd5, 32'h0000_0ABC, 32'h0000_6000, 2'd0, 0, 0, 32'h8000_0301,
            32'h0, 32'h0, "R8 exc no offset");
    // R8: mode 2 interrupt gets no offset
    do_trap(1, 5'd11, 32'h0, 32'h0000_6100, 2'd3, 0, 0, 32'h8000_0402,
            32'h0, 32'h0, "R8 mode2");
    // R10: ecall user delegated -> 8 in supervisor
    do_trap(0, 5'd8, 32'h5555_5555, 32'h0000_7000, 2'd0, 0, 32'h100, 32'h8000_0000,
            32'h4000_0200, 32'h0, "R10 ecall U");
    // R10: ecall supervisor: bit 8 set, bit 9 clear -> machine, cause 9
    do_trap(0, 5'd8, 32'h0, 32'h0000_7100, 2'd1, 0, 32'h100, 32'h8000_0000,
            32'h4000_0200, 32'h0000_0002, "R10 ecall S remap");
    // R10: ecall machine -> 11
    do_trap(0, 5'd8, 32'h0, 32'h0000_7200, 2'd3, 0, '1, 32'h8000_0000,
            32'h0, 32'h0000_0008, "R10 ecall M");
    // R9: interrupt with a fault-like code keeps tval zero
    do_trap(1, 5'd13, 32'h9999_9999, 32'h0000_8000, 2'd0, 0, 0, 32'h8000_0000,
            32'h0, 32'h0, "R9 irq tval");
    // R4 R5: dense status patterns
    do_trap(0, 5'd15, 32'h1234_5678, 32'h0000_9000, 2'd1, 0, 32'h8000, 32'h0,
            32'h4000_0000, 32'hFFFF_FFFF, "R4 dense");
    do_trap(0, 5'd1, 32'h8765_4321, 32'h0000_9100, 2'd1, 0, 0, 32'h8000_0000,
            32'h0, 32'hFFFF_E7FF, "R5 dense");
    // idle gap to observe hold (R11)
    repeat (4) @(negedge clk);

    for (int k = 0; k < 200; k++) begin
      logic [1:0] pr;
      logic [31:0] r;
      r  = $urandom;
      pr = (r[1:0] == 2'd2) ? 2'd3 : r[1:0];
      do_trap(r[2], 5'($urandom), $urandom, $urandom, pr, $urandom, $urandom,
              $urandom, $urandom, $urandom, "random");
      if (r[5]) repeat (int'(r[4:3])) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R11", "pending items", q.size(), 0);
    report();
    $finish;
  end

endmodule